// File: doc/BRIEF.md
# Serial EEPROM Command Engine (Four-Wire Bus Slave)

This block is a synchronous slave that behaves like a small serial EEPROM on a four-wire bus with chip select, serial clock, data in and data out. The array holds 16 words of 16 bits in registers. A system clock samples the bus inputs. The block looks for rising edges of the serial clock and acts on each one while chip select is high.

Every command starts with a 1 start bit. Two opcode bits and a six-bit address field follow, and all of them arrive on the data input. The supported commands are:
- read, which streams words one after another as long as the serial clock keeps running;
- write one word;
- write the whole array;
- enable writes;
- disable writes.

A write is self-timed. A counter of system clock cycles stands in for the programming time. While chip select is high, the data output shows whether programming is still running. A separate input tells the block whether the word being written is protected. When the protect-space select input is high, the command belongs to another instruction space and leaves the array untouched.

Top module: `mwire_eeprom`

## Requirements
- R1: After reset every word reads 16'hFFFF, writes are disabled and `do_oe` is low.
- R2: A command is a 1 start bit, then 2 opcode bits, then 6 address bits, each sent MSB first and taken on a rising `sk` edge. The opcode values are:
  - 10: read
  - 01: write
  - 00: qualified by the two upper address bits, where 11 enables writes, 00 disables writes and 01 writes the whole array.
  Only the 4 low address bits pick a word; the 2 upper bits do not matter for read and write.
- R3: For a read, the `sk` rising edge that carries the last address bit drives a 0 dummy bit on `do_o` with `do_oe` high. Each of the next 16 rising edges drives one data bit, MSB first.
- R4: If `sk` keeps running during a read, the following words stream out with no extra dummy bit. The address wraps from 15 to 0.
- R5: A write takes effect when `cs` falls, and only after all 16 data bits (MSB first) have been received. If `cs` falls before the 16th data bit, nothing is written.
- R6: A write-all stores its data word into every location.
- R7: Enable-writes and disable-writes take effect when `cs` falls. Writes are rejected after reset and after a disable-writes command, until an enable-writes command executes.
- R8: A write is ignored while `pe` is low. It is also ignored when `prot_hit` is high for the target shown on `tgt_addr`, which is the word address for a single write and 0 for a write-all.
- R9: An accepted write keeps the block busy for WRITE_CYCLES clock cycles. If `cs` is high and no command has started, `do_oe` is high and `do_o` shows 0 while busy and 1 once ready. A start bit sent while busy is ignored.
- R10: A start bit received while ready status is shown removes the status from `do_o` (`do_oe` goes low) and begins a new command.
- R11: `do_oe` is low whenever `cs` is low.
- R12: A command whose start bit arrives with `pre` high changes no word and drives no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; rising edges shift bits |
| di | input | 1 | Serial data in |
| pe | input | 1 | Program enable; low blocks writes |
| pre | input | 1 | Selects the protect instruction space |
| prot_hit | input | 1 | High when `tgt_addr` is write-protected |
| tgt_addr | output | 4 | Word address a pending write targets |
| do_o | output | 1 | Serial data / status out |
| do_oe | output | 1 | Drive enable for `do_o` (low = high impedance) |

## Verification
The assertions assume the following about the inputs:
- `cs`, `sk` and `di` are already synchronous to `clk`.
- `sk` stays at each level for at least one clock, so every rising edge is seen exactly once.
- `prot_hit` is a function of `tgt_addr` that settles within the cycle.

The bench meets these by changing the bus pins only on falling clock edges and holding each `sk` level for two clocks. It derives `prot_hit` combinationally from `tgt_addr` and a limit it sets itself. It also lets every accepted write finish before starting the next command, except in the one step that probes a start bit sent while busy.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_WRALL, CMD_WEN, CMD_WDS
  } mw_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_READ, PH_DATA, PH_ARMED, PH_CTRL, PH_DROP
  } mw_phase_e;

  // opcode plus the two upper address bits select the command
  function automatic mw_cmd_e mw_decode(input logic [1:0] op, input logic [1:0] hi);
    mw_cmd_e c;
    case (op)
      2'b10: c = CMD_READ;
      2'b01: c = CMD_WRITE;
      2'b00: begin
        case (hi)
          2'b11:   c = CMD_WEN;
          2'b00:   c = CMD_WDS;
          2'b01:   c = CMD_WRALL;
          default: c = CMD_NONE;
        endcase
      end
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic sk_rise,
  output logic cs_fall
);
  logic sk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q;
  assign cs_fall = cs_q & ~cs;
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int WORDS = 16,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     all,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  localparam int AW = $clog2(WORDS);
  logic [WIDTH-1:0] mem [WORDS];
  logic [WORDS-1:0] sel;

  for (genvar i = 0; i < WORDS; i++) begin : g_sel
    assign sel[i] = we & (all | (waddr == AW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) if (sel[i]) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
  import mw_pkg::*;
#(
  parameter int WORDS        = 16,
  parameter int WIDTH        = 16,
  parameter int AFIELD       = 6,
  parameter int WRITE_CYCLES = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs,
  input  logic                     sk,
  input  logic                     di,
  input  logic                     pe,
  input  logic                     pre,
  input  logic                     prot_hit,
  output logic [$clog2(WORDS)-1:0] tgt_addr,
  output logic                     do_o,
  output logic                     do_oe
);
  localparam int AW  = $clog2(WORDS);
  localparam int HDR = 2 + AFIELD;
  localparam int HCW = $clog2(HDR);
  localparam int DCW = $clog2(WIDTH);

  // named internal events
  logic sk_rise, cs_fall, busy;
  logic start_ok, hdr_done, wr_go, ctl_go, write_ok, stat_show;

  mw_phase_e       phase;
  mw_cmd_e         cmd, dec_cmd;
  logic [HCW-1:0]  hdr_cnt;
  logic [HDR-2:0]  hdr_sr;
  logic [HDR-1:0]  hdr_next;
  logic [AW-1:0]   addr_q, raddr;
  logic [DCW-1:0]  bit_cnt;
  logic [WIDTH-1:0] data_sr, rd_sr, rdata;
  logic            do_q, wen_q, pre_lat, stat_pend;

  mw_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk),
    .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(busy)
  );

  mw_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
    .clk(clk), .rst_n(rst_n), .we(wr_go), .all(cmd == CMD_WRALL),
    .waddr(addr_q), .wdata(data_sr), .raddr(raddr), .rdata(rdata)
  );

  assign hdr_next  = {hdr_sr, di};
  assign dec_cmd   = mw_decode(hdr_next[HDR-1 -: 2], hdr_next[AFIELD-1 -: 2]);
  assign start_ok  = cs && sk_rise && (phase == PH_IDLE) && di && !busy;
  assign hdr_done  = cs && sk_rise && (phase == PH_HDR) && (hdr_cnt == HCW'(HDR-1));
  assign write_ok  = wen_q && pe && !prot_hit && !pre_lat;
  assign wr_go     = cs_fall && (phase == PH_ARMED) &&
                     ((cmd == CMD_WRITE) || (cmd == CMD_WRALL)) && write_ok;
  assign ctl_go    = cs_fall && (phase == PH_CTRL) && !pre_lat;
  assign tgt_addr  = (cmd == CMD_WRALL) ? '0 : addr_q;
  assign raddr     = (phase == PH_READ) ? addr_q + 1'b1 : hdr_next[AW-1:0];
  assign stat_show = cs && stat_pend && (phase == PH_IDLE);
  assign do_oe     = cs && ((phase == PH_READ) || stat_show);
  assign do_o      = (cs && phase == PH_READ) ? do_q : (stat_show ? !busy : 1'b0);

  // status flag and write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      wen_q     <= 1'b0;
    end else begin
      if (wr_go)         stat_pend <= 1'b1;
      else if (start_ok) stat_pend <= 1'b0;
      if (ctl_go && cmd == CMD_WEN)      wen_q <= 1'b1;
      else if (ctl_go && cmd == CMD_WDS) wen_q <= 1'b0;
    end
  end

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cmd     <= CMD_NONE;
      hdr_cnt <= '0;
      hdr_sr  <= '0;
      addr_q  <= '0;
      bit_cnt <= '0;
      data_sr <= '0;
      rd_sr   <= '0;
      do_q    <= 1'b0;
      pre_lat <= 1'b0;
    end else if (!cs) begin
      phase <= PH_IDLE;
    end else if (sk_rise) begin
      case (phase)
        PH_IDLE: if (start_ok) begin
          phase   <= PH_HDR;
          hdr_cnt <= '0;
          pre_lat <= pre;
        end
        PH_HDR: begin
          hdr_sr  <= hdr_next[HDR-2:0];
          hdr_cnt <= hdr_cnt + 1'b1;
          if (hdr_done) begin
            cmd     <= dec_cmd;
            addr_q  <= hdr_next[AW-1:0];
            bit_cnt <= '0;
            if (pre_lat) phase <= PH_DROP;
            else begin
              case (dec_cmd)
                CMD_READ: begin
                  phase <= PH_READ;
                  rd_sr <= rdata;
                  do_q  <= 1'b0;
                end
                CMD_WRITE, CMD_WRALL: phase <= PH_DATA;
                CMD_WEN, CMD_WDS:     phase <= PH_CTRL;
                default:              phase <= PH_DROP;
              endcase
            end
          end
        end
        PH_READ: begin
          do_q    <= rd_sr[WIDTH-1];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == DCW'(WIDTH-1)) begin
            rd_sr   <= rdata;
            addr_q  <= addr_q + 1'b1;
            bit_cnt <= '0;
          end else begin
            rd_sr <= rd_sr << 1;
          end
        end
        PH_DATA: begin
          data_sr <= {data_sr[WIDTH-2:0], di};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == DCW'(WIDTH-1)) phase <= PH_ARMED;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_o,
  input logic do_oe,
  input logic wr_go,
  input logic cs_fall,
  input logic busy,
  input logic stat_show,
  input logic wen_q,
  input logic pe,
  input logic prot_hit,
  input logic pre_lat
);
  assert_hiz_cs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);
  assert_go_on_cs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> cs_fall);
  assert_go_needs_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> wen_q);
  assert_go_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> (pe && !prot_hit));
  assert_go_not_pre_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !pre_lat);
  assert_busy_follows_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> busy);
  assert_no_go_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_go);
  assert_status_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_show |-> (do_oe && (do_o == !busy)));
endmodule

bind mwire_eeprom mwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o), .do_oe(do_oe),
  .wr_go(wr_go), .cs_fall(cs_fall), .busy(busy), .stat_show(stat_show),
  .wen_q(wen_q), .pe(pe), .prot_hit(prot_hit), .pre_lat(pre_lat)
);

// File: tb/mwire_eeprom_test.sv
module mwire_eeprom_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, pe = 1'b1, pre = 1'b0;
  logic prot_hit;
  logic [3:0] tgt_addr;
  logic do_o, do_oe;
  int prot_lim = 16;
  int checks = 0, fails = 0;
  logic [15:0] m [16];
  logic d, oe;

  always #10 clk = ~clk;

  assign prot_hit = (int'(tgt_addr) >= prot_lim);

  mwire_eeprom #(.WRITE_CYCLES(30)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pe(pe), .pre(pre),
    .prot_hit(prot_hit), .tgt_addr(tgt_addr), .do_o(do_o), .do_oe(do_oe)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // every clock: bus released while deselected (R11)
  always @(negedge clk) begin
    if (rst_n && !cs) begin
      checks++;
      if (do_oe !== 1'b0) begin
        fails++;
        $display("FAIL R11 actual=%b expected=0", do_oe);
      end
    end
  end

  task automatic cs_up();
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) begin cs = 1'b0; sk = 1'b0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic dq, output logic oq);
    @(negedge clk) di = b;
    @(negedge clk) sk = 1'b1;
    @(negedge clk) begin dq = do_o; oq = do_oe; end
    @(negedge clk) sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [5:0] a,
                        output logic dq, output logic oq);
    clk_bit(1'b1, dq, oq);
    for (int i = 1; i >= 0; i--) clk_bit(op[i], dq, oq);
    for (int i = 5; i >= 0; i--) clk_bit(a[i], dq, oq);
  endtask

  task automatic read_words(input logic [5:0] a, input int n, input string rq);
    logic [15:0] w;
    logic dq, oq;
    cs_up();
    header(2'b10, a, dq, oq);
    check({rq, " R3 dummy"}, {oq, dq}, 2'b10);
    for (int k = 0; k < n; k++) begin
      for (int i = 15; i >= 0; i--) begin
        clk_bit(1'b0, dq, oq);
        w[i] = dq;
      end
      check(rq, w, m[(int'(a[3:0]) + k) % 16]);
    end
    cs_down();
  endtask

  task automatic write_cmd(input logic [1:0] op, input logic [5:0] a,
                           input logic [15:0] v, input int nbits);
    logic dq, oq;
    cs_up();
    header(op, a, dq, oq);
    for (int i = 15; i > 15 - nbits; i--) clk_bit(v[i], dq, oq);
    cs_down();
    repeat (40) @(negedge clk);
  endtask

  task automatic ctrl(input logic [5:0] a);
    logic dq, oq;
    cs_up();
    header(2'b00, a, dq, oq);
    cs_down();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 do_oe", do_oe, 1'b0);
    read_words(6'd0, 1, "R1 reset word");

    // R7: write rejected before enabling
    write_cmd(2'b01, 6'd3, 16'h1234, 16);
    read_words(6'd3, 1, "R7 disabled after reset");

    // enable, then a timed write with status (R9, R10, R2, R5)
    ctrl(6'b110000);
    cs_up();
    header(2'b01, 6'd3, d, oe);
    for (int i = 15; i >= 0; i--) clk_bit(16'hA5C3 >> i, d, oe);
    cs_down();
    m[3] = 16'hA5C3;
    cs_up();
    @(negedge clk);
    check("R9 busy status", {do_oe, do_o}, 2'b10);
    clk_bit(1'b1, d, oe);
    check("R9 start ignored while busy", {oe, d}, 2'b10);
    repeat (35) @(negedge clk);
    check("R9 ready status", {do_oe, do_o}, 2'b11);
    clk_bit(1'b1, d, oe);
    check("R10 status cleared", oe, 1'b0);
    clk_bit(1'b1, d, oe);
    clk_bit(1'b0, d, oe);
    for (int i = 5; i >= 0; i--) clk_bit(6'b100011 >> i, d, oe);
    check("R10 dummy", {oe, d}, 2'b10);
    begin
      logic [15:0] w;
      for (int i = 15; i >= 0; i--) begin clk_bit(1'b0, d, oe); w[i] = d; end
      check("R2 upper bits ignored / R5 word", w, 16'hA5C3);
    end
    cs_down();

    // R5: short write leaves word alone
    write_cmd(2'b01, 6'd5, 16'h0000, 10);
    read_words(6'd5, 1, "R5 short write");

    // R8: pe low, then protection
    pe = 1'b0;
    write_cmd(2'b01, 6'd6, 16'h0000, 16);
    pe = 1'b1;
    read_words(6'd6, 1, "R8 pe low");
    prot_lim = 8;
    write_cmd(2'b01, 6'd9, 16'h9999, 16);
    write_cmd(2'b01, 6'd2, 16'h2222, 16);
    m[2] = 16'h2222;
    prot_lim = 16;
    read_words(6'd9, 1, "R8 protected");
    read_words(6'd2, 1, "R8 unprotected");

    // R6: write-all, then distinct words for streaming (R4)
    write_cmd(2'b00, 6'b010000, 16'h0F0F, 16);
    for (int i = 0; i < 16; i++) m[i] = 16'h0F0F;
    read_words(6'd7, 1, "R6 write-all");
    write_cmd(2'b01, 6'd14, 16'hE0E0, 16); m[14] = 16'hE0E0;
    write_cmd(2'b01, 6'd15, 16'hF00F, 16); m[15] = 16'hF00F;
    write_cmd(2'b01, 6'd0,  16'h0001, 16); m[0]  = 16'h0001;
    read_words(6'd14, 4, "R4 sequential wrap");

    // R12: protect space leaves the array alone and drives nothing
    pre = 1'b1;
    write_cmd(2'b01, 6'd7, 16'h7777, 16);
    cs_up();
    header(2'b10, 6'd7, d, oe);
    check("R12 no read output", oe, 1'b0);
    cs_down();
    pre = 1'b0;
    read_words(6'd7, 1, "R12 word kept");

    // R7: disable, then write is rejected
    ctrl(6'b000000);
    write_cmd(2'b01, 6'd8, 16'h8888, 16);
    read_words(6'd8, 1, "R7 after disable");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule